// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps coherence bookkeeping for a table of memory lines. It does not use a full presence vector of one bit per cache. Each line's entry holds a small, fixed number of cache-ID pointers, each with its own valid bit, plus a dirty (exclusive) flag and an overflow flag. The design assumes the usual case, where a line is held by only two or three caches at once. A coherence engine issues one request per cycle: add a sharer, write, remove a sharer, or invalidate the line. One cycle later the block answers with the caches that must be invalidated and the state the entry has after the update.

When a new sharer arrives and every pointer slot is in use, a build-time parameter selects one of two behaviours. Under the broadcast policy the entry raises its overflow flag and keeps its pointers. Any later invalidation of that line then goes to every cache. Under the eviction policy the block forces out the sharer held in the lowest-numbered valid slot, reports that cache's ID for one cycle, and puts the requester in the freed slot. Message transport is handled elsewhere. This block only produces target vectors, a broadcast indication and an eviction victim.

Top module: `lptr_directory`

## Requirements
- R1: After a synchronous reset every line has no sharers and clear dirty and overflow flags, and all response outputs are zero.
- R2: A read request (op code 0) places the requesting ID in the lowest-numbered free pointer slot. An ID already recorded for the line does not take a second slot.
- R3: Each request gets exactly one response cycle, one clock after it is sampled. In cycles with no response, every response output is zero.
- R4: With the broadcast policy, a read from an unrecorded ID when all slots are full sets the overflow flag. It leaves the recorded sharers unchanged and reports no eviction.
- R5: With the eviction policy, such a read evicts the ID in the lowest-numbered valid slot and shows it on the eviction outputs for that response cycle only. The requester takes that slot, and the overflow flag stays clear.
- R6: A write request (op code 1) on a line without overflow returns the recorded sharers minus the writer as targets, with broadcast low. Afterwards the writer is the only sharer and the dirty flag is set.
- R7: A write or invalidate request on an overflowed line raises broadcast. The write targets every cache except the writer, and the invalidate targets every cache. Both clear the overflow flag.
- R8: A remove request (op code 2) frees the slot holding that ID and does not change the overflow flag. If no sharer remains, dirty clears. An absent ID changes nothing.
- R9: An invalidate request (op code 3) returns the recorded sharers as targets and leaves the line with no sharers and clear flags.
- R10: A read request clears the line's dirty flag.
- R11: A request changes only the entry of the line it names.
- R12: Bit k of every target and sharer vector stands for cache ID k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 remove, 3 invalidate |
| req_line | input | log2(NLINES) | Line index |
| req_id | input | log2(NCACHE) | Requesting cache ID |
| rsp_valid | output | 1 | Response cycle |
| rsp_targets | output | NCACHE | Caches to invalidate |
| rsp_bcast | output | 1 | Invalidation must go to all caches |
| rsp_evict_valid | output | 1 | A forced eviction happened |
| rsp_evict_id | output | log2(NCACHE) | ID of the evicted sharer |
| rsp_sharers | output | NCACHE | Sharers of the line after the update |
| rsp_ovf | output | 1 | Overflow flag after the update |
| rsp_dirty | output | 1 | Dirty flag after the update |

## Verification
The bench fills a line to capacity and then adds one more sharer under both policies. A design that picked the wrong victim, or that kept the eviction pulse for more than one cycle, reports the wrong ID or a stale eviction. It repeats a read from an ID that is already recorded, which catches a design that spends a second slot on it. It removes a sharer from an overflowed line and then invalidates the line, which exposes a design that clears overflow too early or sends the invalidate to the pointers only. Writes by a sole sharer and by a new owner check that the writer never appears in its own targets. Remove requests that free the last slot, or that name an absent ID, check when the dirty flag may clear.

// File: rtl/lptr_dir_pkg.sv
`timescale 1ns/1ps
package lptr_dir_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_REMOVE = 2'd2,
    OP_FLUSH  = 2'd3
  } dir_op_e;
endpackage

// File: rtl/lptr_first_set.sv
`timescale 1ns/1ps
// Lowest-index set bit finder.
module lptr_first_set #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end

  always_comb begin
    if (found) begin
      // R2
      pick_is_set_chk: assert (vec[idx]);
    end
  end
endmodule

// File: rtl/lptr_slot_cmp.sv
`timescale 1ns/1ps
// Per-slot ID comparison and free-slot map.
module lptr_slot_cmp #(
  parameter int NPTR = 3,
  parameter int IDW  = 3
) (
  input  logic [NPTR*IDW-1:0] ptrs,
  input  logic [NPTR-1:0]     vld,
  input  logic [IDW-1:0]      id,
  output logic [NPTR-1:0]     hit,
  output logic [NPTR-1:0]     free
);
  for (genvar s = 0; s < NPTR; s++) begin : g_slot
    assign hit[s]  = vld[s] && (ptrs[s*IDW +: IDW] == id);
    assign free[s] = !vld[s];
  end
endmodule

// File: rtl/lptr_presence.sv
`timescale 1ns/1ps
// Decodes valid pointers into a presence vector over all caches.
module lptr_presence #(
  parameter int NPTR   = 3,
  parameter int IDW    = 3,
  parameter int NCACHE = 8
) (
  input  logic [NPTR*IDW-1:0] ptrs,
  input  logic [NPTR-1:0]     vld,
  output logic [NCACHE-1:0]   pres
);
  logic [NCACHE-1:0] dec [NPTR];

  for (genvar s = 0; s < NPTR; s++) begin : g_dec
    always_comb begin
      dec[s] = '0;
      if (vld[s]) dec[s][ptrs[s*IDW +: IDW]] = 1'b1;
    end
  end

  always_comb begin
    pres = '0;
    for (int s = 0; s < NPTR; s++) pres = pres | dec[s];
  end
endmodule

// File: rtl/lptr_directory.sv
`timescale 1ns/1ps
module lptr_directory
  import lptr_dir_pkg::*;
#(
  parameter int NCACHE       = 8,
  parameter int NPTR         = 3,
  parameter int NLINES       = 16,
  parameter bit BCAST_ON_OVF = 1'b1,
  localparam int IDW = $clog2(NCACHE),
  localparam int LW  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [LW-1:0]     req_line,
  input  logic [IDW-1:0]    req_id,
  output logic              rsp_valid,
  output logic [NCACHE-1:0] rsp_targets,
  output logic              rsp_bcast,
  output logic              rsp_evict_valid,
  output logic [IDW-1:0]    rsp_evict_id,
  output logic [NCACHE-1:0] rsp_sharers,
  output logic              rsp_ovf,
  output logic              rsp_dirty
);
  localparam int PW = NPTR * IDW;
  localparam int SW = (NPTR > 1) ? $clog2(NPTR) : 1;

  // Pointer field: plain memory with no reset; validity lives in flops.
  logic [PW-1:0]     ptr_mem [NLINES];
  logic [NPTR-1:0]   vld_mem [NLINES];
  logic [NLINES-1:0] dirty_q;
  logic [NLINES-1:0] ovf_q;

  logic [PW-1:0]   cur_ptr, nxt_ptr;
  logic [NPTR-1:0] cur_vld, nxt_vld;
  logic            cur_dirty, nxt_dirty, cur_ovf, nxt_ovf;
  logic [NPTR-1:0] hit, free;
  logic            free_found, vic_found;
  logic [SW-1:0]   free_idx, vic_idx;
  logic [NCACHE-1:0] cur_pres, nxt_pres, tgt;
  logic            bc, ev;
  logic [IDW-1:0]  evid;
  dir_op_e         op;

  assign op        = dir_op_e'(req_op);
  assign cur_ptr   = ptr_mem[req_line];
  assign cur_vld   = vld_mem[req_line];
  assign cur_dirty = dirty_q[req_line];
  assign cur_ovf   = ovf_q[req_line];

  lptr_slot_cmp #(.NPTR(NPTR), .IDW(IDW)) u_cmp (
    .ptrs(cur_ptr), .vld(cur_vld), .id(req_id), .hit(hit), .free(free)
  );

  lptr_first_set #(.W(NPTR), .IW(SW)) u_free_pick (
    .vec(free), .found(free_found), .idx(free_idx)
  );

  lptr_first_set #(.W(NPTR), .IW(SW)) u_vic_pick (
    .vec(cur_vld), .found(vic_found), .idx(vic_idx)
  );

  lptr_presence #(.NPTR(NPTR), .IDW(IDW), .NCACHE(NCACHE)) u_cur_pres (
    .ptrs(cur_ptr), .vld(cur_vld), .pres(cur_pres)
  );

  lptr_presence #(.NPTR(NPTR), .IDW(IDW), .NCACHE(NCACHE)) u_nxt_pres (
    .ptrs(nxt_ptr), .vld(nxt_vld), .pres(nxt_pres)
  );

  always_comb begin
    nxt_ptr   = cur_ptr;
    nxt_vld   = cur_vld;
    nxt_dirty = cur_dirty;
    nxt_ovf   = cur_ovf;
    tgt       = '0;
    bc        = 1'b0;
    ev        = 1'b0;
    evid      = '0;
    case (op)
      OP_READ: begin
        nxt_dirty = 1'b0;
        if (|hit) begin
          nxt_vld = cur_vld;
        end else if (free_found) begin
          nxt_vld[free_idx] = 1'b1;
          nxt_ptr[int'(free_idx)*IDW +: IDW] = req_id;
        end else if (BCAST_ON_OVF) begin
          nxt_ovf = 1'b1;
        end else if (vic_found) begin
          ev   = 1'b1;
          evid = cur_ptr[int'(vic_idx)*IDW +: IDW];
          nxt_ptr[int'(vic_idx)*IDW +: IDW] = req_id;
        end
      end
      OP_WRITE: begin
        bc  = cur_ovf;
        tgt = cur_ovf ? '1 : cur_pres;
        tgt[req_id] = 1'b0;
        nxt_vld    = '0;
        nxt_vld[0] = 1'b1;
        nxt_ptr[IDW-1:0] = req_id;
        nxt_dirty = 1'b1;
        nxt_ovf   = 1'b0;
      end
      OP_REMOVE: begin
        nxt_vld = cur_vld & ~hit;
        if (nxt_vld == '0) nxt_dirty = 1'b0;
      end
      default: begin
        bc        = cur_ovf;
        tgt       = cur_ovf ? '1 : cur_pres;
        nxt_vld   = '0;
        nxt_dirty = 1'b0;
        nxt_ovf   = 1'b0;
      end
    endcase
  end

  // Pointer storage write port.
  always_ff @(posedge clk) begin
    if (req_valid) ptr_mem[req_line] <= nxt_ptr;
  end

  // Entry state and registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NLINES; l++) vld_mem[l] <= '0;
      dirty_q         <= '0;
      ovf_q           <= '0;
      rsp_valid       <= 1'b0;
      rsp_targets     <= '0;
      rsp_bcast       <= 1'b0;
      rsp_evict_valid <= 1'b0;
      rsp_evict_id    <= '0;
      rsp_sharers     <= '0;
      rsp_ovf         <= 1'b0;
      rsp_dirty       <= 1'b0;
    end else begin
      rsp_valid       <= req_valid;
      rsp_targets     <= '0;
      rsp_bcast       <= 1'b0;
      rsp_evict_valid <= 1'b0;
      rsp_evict_id    <= '0;
      rsp_sharers     <= '0;
      rsp_ovf         <= 1'b0;
      rsp_dirty       <= 1'b0;
      if (req_valid) begin
        vld_mem[req_line]  <= nxt_vld;
        dirty_q[req_line]  <= nxt_dirty;
        ovf_q[req_line]    <= nxt_ovf;
        rsp_targets        <= tgt;
        rsp_bcast          <= bc;
        rsp_evict_valid    <= ev;
        rsp_evict_id       <= evid;
        rsp_sharers        <= nxt_pres;
        rsp_ovf            <= nxt_ovf;
        rsp_dirty          <= nxt_dirty;
      end
    end
  end

  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  // R3
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_targets == '0 && !rsp_bcast && !rsp_evict_valid && rsp_sharers == '0));

  // R5
  evict_only_nb_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_evict_valid |-> (!BCAST_ON_OVF && rsp_valid && $past(req_op) == OP_READ));

  // R4
  ovf_only_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ovf |-> BCAST_ON_OVF);

  // R2
  slot_capacity_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(rsp_sharers) <= NPTR);

  // R6
  writer_excluded_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_op) == OP_WRITE) |-> !rsp_targets[$past(req_id)]);

  // R6
  writer_owns_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_op) == OP_WRITE) |->
      (rsp_dirty && !rsp_ovf && $onehot0(rsp_sharers) && rsp_sharers[$past(req_id)]));

  // R7
  bcast_source_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_bcast |-> (rsp_valid && ($past(req_op) == OP_WRITE || $past(req_op) == OP_FLUSH)));
endmodule

// File: tb/lptr_directory_tb.sv
`timescale 1ns/1ps
module lptr_directory_tb_top;
  localparam int NCACHE = 8;
  localparam int NPTR   = 3;
  localparam int NLINES = 16;
  localparam int IDW    = $clog2(NCACHE);
  localparam int LW     = $clog2(NLINES);
  localparam int NV     = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [LW-1:0] req_line = '0;
  logic [IDW-1:0] req_id = '0;

  logic a_v, a_bc, a_ev, a_ovf, a_dt;
  logic [NCACHE-1:0] a_tgt, a_sh;
  logic [IDW-1:0] a_eid;
  logic b_v, b_bc, b_ev, b_ovf, b_dt;
  logic [NCACHE-1:0] b_tgt, b_sh;
  logic [IDW-1:0] b_eid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lptr_directory #(.NCACHE(NCACHE), .NPTR(NPTR), .NLINES(NLINES), .BCAST_ON_OVF(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_line(req_line),
    .req_id(req_id), .rsp_valid(a_v), .rsp_targets(a_tgt), .rsp_bcast(a_bc),
    .rsp_evict_valid(a_ev), .rsp_evict_id(a_eid), .rsp_sharers(a_sh),
    .rsp_ovf(a_ovf), .rsp_dirty(a_dt));

  lptr_directory #(.NCACHE(NCACHE), .NPTR(NPTR), .NLINES(NLINES), .BCAST_ON_OVF(1'b0)) dut_nb (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_line(req_line),
    .req_id(req_id), .rsp_valid(b_v), .rsp_targets(b_tgt), .rsp_bcast(b_bc),
    .rsp_evict_valid(b_ev), .rsp_evict_id(b_eid), .rsp_sharers(b_sh),
    .rsp_ovf(b_ovf), .rsp_dirty(b_dt));

  // Row: {op, line, id, sharers, targets, bcast, evict_v, evict_id, ovf, dirty}
  localparam logic [31:0] VEC [NV] = '{
    {2'd0,4'd2,3'd1, 8'h02,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R2 R12 first sharer
    {2'd0,4'd2,3'd1, 8'h02,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R2 duplicate id
    {2'd0,4'd2,3'd4, 8'h12,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R2
    {2'd0,4'd2,3'd6, 8'h52,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R2 full
    {2'd0,4'd2,3'd3, 8'h52,8'h00,1'b0,1'b0,3'd0,1'b1,1'b0}, // R4 overflow
    {2'd1,4'd2,3'd4, 8'h10,8'hEF,1'b1,1'b0,3'd0,1'b0,1'b1}, // R7 write on overflow
    {2'd0,4'd2,3'd5, 8'h30,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R10 read clears dirty
    {2'd1,4'd2,3'd5, 8'h20,8'h10,1'b0,1'b0,3'd0,1'b0,1'b1}, // R6
    {2'd2,4'd2,3'd5, 8'h00,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R8 last sharer gone
    {2'd0,4'd7,3'd0, 8'h01,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R11 other line
    {2'd0,4'd2,3'd2, 8'h04,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R11 line 2 untouched
    {2'd3,4'd7,3'd0, 8'h00,8'h01,1'b0,1'b0,3'd0,1'b0,1'b0}, // R9
    {2'd0,4'd2,3'd7, 8'h84,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R2
    {2'd0,4'd2,3'd0, 8'h85,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}, // R2
    {2'd0,4'd2,3'd1, 8'h85,8'h00,1'b0,1'b0,3'd0,1'b1,1'b0}, // R4
    {2'd2,4'd2,3'd7, 8'h05,8'h00,1'b0,1'b0,3'd0,1'b1,1'b0}, // R8 overflow kept
    {2'd3,4'd2,3'd0, 8'h00,8'hFF,1'b1,1'b0,3'd0,1'b0,1'b0}, // R7 R9 flush overflowed
    {2'd1,4'd9,3'd3, 8'h08,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1}, // R6 empty line
    {2'd2,4'd9,3'd5, 8'h08,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1}, // R8 absent id
    {2'd1,4'd9,3'd3, 8'h08,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1}, // R6 sole writer
    {2'd0,4'd9,3'd3, 8'h08,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0}  // R10
  };
  localparam int VREQ [NV] = '{2,2,2,2,4,7,10,6,8,11,11,9,2,2,4,8,7,6,8,6,10};

  function automatic logic [23:0] pk_a();
    return {a_v, a_sh, a_tgt, a_bc, a_ev, a_eid, a_ovf, a_dt};
  endfunction
  function automatic logic [23:0] pk_b();
    return {b_v, b_sh, b_tgt, b_bc, b_ev, b_eid, b_ovf, b_dt};
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; the response is registered at the next rising
  // edge and read at the following falling edge.
  task automatic do_op(input logic [1:0] op, input logic [LW-1:0] ln, input logic [IDW-1:0] id);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_line = ln; req_id = id;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 reset outputs", pk_a(), 24'h0);
    rst = 1'b0;
    idle();
    chk("R3 idle before traffic", pk_b(), 24'h0);

    for (int v = 0; v < NV; v++) begin
      do_op(VEC[v][31:30], VEC[v][29:26], VEC[v][25:23]);
      chk($sformatf("R%0d vector %0d", VREQ[v], v), pk_a(), {1'b1, VEC[v][22:0]});
    end

    // R3: no response in the cycle after a response
    idle();
    chk("R3 idle after request", pk_a(), 24'h0);

    // R1: reset empties populated lines (line 9 held cache 3)
    rst = 1'b1;
    idle(); idle();
    chk("R1 outputs in reset", pk_a(), 24'h0);
    rst = 1'b0;
    do_op(2'd2, 4'd9, 3'd0);
    chk("R1 line 9 empty after reset", pk_a(), {1'b1, 8'h00,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0});

    // R5 and R4 on line 5
    do_op(2'd0, 4'd5, 3'd1);
    do_op(2'd0, 4'd5, 3'd2);
    do_op(2'd0, 4'd5, 3'd3);
    chk("R2 nb fill", pk_b(), {1'b1, 8'h0E,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0});
    do_op(2'd0, 4'd5, 3'd6);
    chk("R5 evict lowest slot", pk_b(), {1'b1, 8'h4C,8'h00,1'b0,1'b1,3'd1,1'b0,1'b0});
    chk("R4 bcast policy no evict", pk_a(), {1'b1, 8'h0E,8'h00,1'b0,1'b0,3'd0,1'b1,1'b0});
    idle();
    chk("R5 evict lasts one cycle", pk_b(), 24'h0);
    do_op(2'd0, 4'd5, 3'd7);
    chk("R5 evict refilled slot", pk_b(), {1'b1, 8'h8C,8'h00,1'b0,1'b1,3'd6,1'b0,1'b0});
    do_op(2'd1, 4'd5, 3'd2);
    chk("R6 nb write targets", pk_b(), {1'b1, 8'h04,8'h88,1'b0,1'b0,3'd0,1'b0,1'b1});
    chk("R7 bcast write after overflow", pk_a(), {1'b1, 8'h04,8'hFB,1'b1,1'b0,3'd0,1'b0,1'b1});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule